// File: doc/BRIEF.md
# Nibble-Serial Register Access Decoder

This block sits behind a byte-wide host link and turns a stream of one-byte commands into accesses to a small bank of 8-bit registers. Each command byte splits into an opcode in its upper half and a 4-bit operand in its lower half. Because an operand holds only four bits, the block builds a full 8-bit register address and a full 8-bit write value from two nibbles each, and it holds the first half until the second half arrives.

The write side is a bank of control registers whose contents are driven out of the block. The read side is a separate set of status bytes that comes in from surrounding logic. A read and a write at the same address therefore reach different storage. Only the lowest `CORE_REGS` addresses are backed on either side. Higher addresses are still accepted on the link: a write to one of them raises the strobe and changes no register, and a read from one returns all ones. A read command can also step the address up or down by one after the access, so that a host can walk through the register file without reloading the address.

Top module: `nib_reg_access`

## Requirements
- R1: After reset, `rd_valid` and `wr_stb` are 0, every byte of `ctrl_regs` is 0x00, and both the address and the low data nibble are 0, so a read with no adjustment returns status byte 0.
- R2: Command byte bits 7:4 are the opcode and bits 3:0 the operand. Opcode 0x0 loads address bits 3:0 and opcode 0x1 loads address bits 7:4. Each leaves the other half of the address unchanged.
- R3: Opcode 0x2 stores the operand as data bits 3:0. Opcode 0x3 supplies data bits 7:4 and commits the byte. `wr_stb` is high for exactly the one cycle after the accepting edge, and `wr_addr` and `wr_data` carry the address and the assembled byte during that cycle.
- R4: A commit to an address below 16 updates byte `addr` of `ctrl_regs` (bits 8*addr+7 : 8*addr) in the same cycle that `wr_stb` rises. A commit to address 0x10 or above pulses `wr_stb` and leaves all of `ctrl_regs` unchanged.
- R5: Opcode 0x4 reads the current address. `rd_valid` is high for exactly the one cycle after the accepting edge, and `rd_data` holds byte `addr` of `stat_regs` (bits 8*addr+7 : 8*addr) during that cycle.
- R6: A read from address 0x10 or above returns 0xFF.
- R7: In a read operand, bit 0 set moves the address by one after the access. Bit 1 set means decrement and bit 1 clear means increment. With bit 0 clear the address stays put, whatever bit 1 holds. The read itself always uses the address from before the adjustment.
- R8: Address adjustment wraps modulo 256: 0xFF steps up to 0x00 and 0x00 steps down to 0xFF.
- R9: Read data comes only from `stat_regs`. A committed write never changes what a read of the same address returns.
- R10: Opcodes 0x5 to 0xF have no effect. The address and the low data nibble keep their values, and neither `wr_stb` nor `rd_valid` rises.
- R11: While `cmd_valid` is low, `cmd_byte` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | `cmd_byte` is accepted at the rising edge while this is high |
| cmd_byte | input | 8 | Command: opcode in bits 7:4, operand in bits 3:0 |
| stat_regs | input | 128 | Read-side status bytes, byte i at bits 8i+7:8i |
| rd_valid | output | 1 | One-cycle pulse that marks returned read data |
| rd_data | output | 8 | Returned read byte |
| wr_stb | output | 1 | One-cycle pulse for each committed write |
| wr_addr | output | 8 | Address of the committed write |
| wr_data | output | 8 | Byte of the committed write |
| ctrl_regs | output | 128 | Write-side control bytes, byte i at bits 8i+7:8i |

## Verification
Every visible result of a command is due one clock edge after the command is accepted. `rd_valid`/`rd_data`, `wr_stb`/`wr_addr`/`wr_data` and the `ctrl_regs` byte all settle at that edge, and any address change caused by a read also takes effect at that edge and is first seen by the next read. The bench drives each command on a falling edge, so it is accepted at the following rising edge. It checks the outputs on the next falling edge, and checks on the falling edge after that that each pulse has dropped. The address cannot be seen directly, so the bench infers it from the status byte that a non-adjusting read returns.

// File: rtl/nra_pkg.sv
package nra_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0] opcode_t;

  localparam opcode_t OPC_ADDR_LO = 4'h0;
  localparam opcode_t OPC_ADDR_HI = 4'h1;
  localparam opcode_t OPC_DATA_LO = 4'h2;
  localparam opcode_t OPC_COMMIT  = 4'h3;
  localparam opcode_t OPC_READ    = 4'h4;

  // read operand bit positions
  localparam int ADJ_EN_BIT   = 0;
  localparam int ADJ_DOWN_BIT = 1;

  typedef struct packed {
    logic             addr_lo;
    logic             addr_hi;
    logic             data_lo;
    logic             commit;
    logic             read;
    logic [NIB_W-1:0] operand;
  } nra_cmd_t;
endpackage

// File: rtl/nra_rst_sync.sv
module nra_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/nra_decode.sv
module nra_decode
  import nra_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output nra_cmd_t          cmd
);
  opcode_t op;
  assign op = cmd_byte[BYTE_W-1:NIB_W];

  always_comb begin
    cmd         = '0;
    cmd.operand = cmd_byte[NIB_W-1:0];
    if (cmd_valid) begin
      case (op)
        OPC_ADDR_LO: cmd.addr_lo = 1'b1;
        OPC_ADDR_HI: cmd.addr_hi = 1'b1;
        OPC_DATA_LO: cmd.data_lo = 1'b1;
        OPC_COMMIT:  cmd.commit  = 1'b1;
        OPC_READ:    cmd.read    = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/nra_addr_ctr.sv
module nra_addr_ctr
  import nra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  nra_cmd_t          cmd,
  output logic [BYTE_W-1:0] addr_q
);
  logic [BYTE_W-1:0] addr_d;
  logic              addr_en;
  logic              adj_go;
  logic              adj_down;

  assign adj_go   = cmd.read && cmd.operand[ADJ_EN_BIT];
  assign adj_down = cmd.operand[ADJ_DOWN_BIT];

  always_comb begin
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (cmd.addr_lo) begin
      addr_d[NIB_W-1:0] = cmd.operand;
      addr_en           = 1'b1;
    end
    if (cmd.addr_hi) begin
      addr_d[BYTE_W-1:NIB_W] = cmd.operand;
      addr_en                = 1'b1;
    end
    if (adj_go) begin
      addr_d  = adj_down ? (addr_q - 1'b1) : (addr_q + 1'b1);
      addr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R8
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adj_go && !adj_down && (addr_q == {BYTE_W{1'b1}}) |=> addr_q == '0);
  // R8
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adj_go && adj_down && (addr_q == '0) |=> addr_q == {BYTE_W{1'b1}});
  // R7
  no_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.read && !cmd.operand[ADJ_EN_BIT] |=> $stable(addr_q));
endmodule

// File: rtl/nra_wdata.sv
module nra_wdata
  import nra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  nra_cmd_t          cmd,
  input  logic [BYTE_W-1:0] addr_q,
  output logic              commit_en,
  output logic [BYTE_W-1:0] commit_byte,
  output logic              wr_stb_q,
  output logic [BYTE_W-1:0] wr_addr_q,
  output logic [BYTE_W-1:0] wr_data_q
);
  logic [NIB_W-1:0] lo_q;

  assign commit_en   = cmd.commit;
  assign commit_byte = {cmd.operand, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lo_q <= '0;
    else if (cmd.data_lo) lo_q <= cmd.operand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_stb_q <= 1'b0;
    else        wr_stb_q <= commit_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (commit_en) begin
      wr_addr_q <= addr_q;
      wr_data_q <= commit_byte;
    end
  end

  // R3
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> !wr_stb_q);
  // R10
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.data_lo |=> $stable(lo_q));
endmodule

// File: rtl/nra_bank.sv
module nra_bank
  import nra_pkg::*;
#(
  parameter int          CORE_REGS   = 16,
  parameter logic [7:0]  UNMAPPED_RD = 8'hFF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BYTE_W-1:0]           addr_q,
  input  logic                        commit_en,
  input  logic [BYTE_W-1:0]           commit_byte,
  input  logic                        rd_req,
  input  logic [CORE_REGS*BYTE_W-1:0] stat_regs,
  output logic [CORE_REGS*BYTE_W-1:0] ctrl_regs,
  output logic                        rd_valid_q,
  output logic [BYTE_W-1:0]           rd_data_q
);
  localparam int IDX_W = (CORE_REGS > 1) ? $clog2(CORE_REGS) : 1;

  logic             in_core;
  logic [IDX_W-1:0] idx;
  logic [BYTE_W-1:0] stat_sel;
  logic [BYTE_W-1:0] rd_byte;

  assign in_core = (int'(addr_q) < CORE_REGS);
  assign idx     = addr_q[IDX_W-1:0];

  generate
    for (genvar g = 0; g < CORE_REGS; g++) begin : g_ctl
      logic wen;
      assign wen = commit_en && in_core && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ctrl_regs[g*BYTE_W +: BYTE_W] <= '0;
        else if (wen) ctrl_regs[g*BYTE_W +: BYTE_W] <= commit_byte;
      end
    end
  endgenerate

  always_comb begin
    stat_sel = '0;
    for (int i = 0; i < CORE_REGS; i++) begin
      if (idx == IDX_W'(i)) stat_sel = stat_regs[i*BYTE_W +: BYTE_W];
    end
  end

  assign rd_byte = in_core ? stat_sel : UNMAPPED_RD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data_q <= '0;
    else if (rd_req) rd_data_q <= rd_byte;
  end

  // R4
  high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en && !in_core |=> $stable(ctrl_regs));
  // R9
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> $stable(ctrl_regs));
  // R6
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !in_core |=> rd_data_q == UNMAPPED_RD);
endmodule

// File: rtl/nib_reg_access.sv
module nib_reg_access
  import nra_pkg::*;
#(
  parameter int         CORE_REGS   = 16,
  parameter logic [7:0] UNMAPPED_RD = 8'hFF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [7:0]                  cmd_byte,
  input  logic [CORE_REGS*8-1:0]      stat_regs,
  output logic                        rd_valid,
  output logic [7:0]                  rd_data,
  output logic                        wr_stb,
  output logic [7:0]                  wr_addr,
  output logic [7:0]                  wr_data,
  output logic [CORE_REGS*8-1:0]      ctrl_regs
);
  logic              rst_n_s;
  nra_cmd_t          cmd;
  logic [BYTE_W-1:0] addr_q;
  logic              commit_en;
  logic [BYTE_W-1:0] commit_byte;

  nra_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  nra_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .cmd       (cmd)
  );

  nra_addr_ctr u_addr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .cmd    (cmd),
    .addr_q (addr_q)
  );

  nra_wdata u_wdat (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cmd         (cmd),
    .addr_q      (addr_q),
    .commit_en   (commit_en),
    .commit_byte (commit_byte),
    .wr_stb_q    (wr_stb),
    .wr_addr_q   (wr_addr),
    .wr_data_q   (wr_data)
  );

  nra_bank #(
    .CORE_REGS   (CORE_REGS),
    .UNMAPPED_RD (UNMAPPED_RD)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .addr_q      (addr_q),
    .commit_en   (commit_en),
    .commit_byte (commit_byte),
    .rd_req      (cmd.read),
    .stat_regs   (stat_regs),
    .ctrl_regs   (ctrl_regs),
    .rd_valid_q  (rd_valid),
    .rd_data_q   (rd_data)
  );

  // R10
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({cmd.addr_lo, cmd.addr_hi, cmd.data_lo, cmd.commit, cmd.read}));
  // R10
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_valid && (cmd_byte[7:4] > OPC_READ) |=> $stable(addr_q) && !wr_stb && !rd_valid);
  // R5
  read_ret_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_valid && (cmd_byte[7:4] == OPC_READ) |=> rd_valid);
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cmd_valid |=> $stable(addr_q) && !wr_stb && !rd_valid);
endmodule

// File: tb/sim_nib_reg_access.sv
module sim_nib_reg_access;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [7:0]   cmd_byte;
  logic [127:0] stat_regs;
  logic         rd_valid;
  logic [7:0]   rd_data;
  logic         wr_stb;
  logic [7:0]   wr_addr;
  logic [7:0]   wr_data;
  logic [127:0] ctrl_regs;
  logic [127:0] exp_ctl;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  nib_reg_access u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .stat_regs (stat_regs),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl_regs (ctrl_regs)
  );

  function automatic logic [7:0] sval(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] rexp(logic [7:0] a);
    return (a < 8'h10) ? sval(int'(a)) : 8'hFF;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
  endtask

  task automatic set_addr(logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic read_chk(string req, logic [3:0] opnd, logic [7:0] exp);
    send({4'h4, opnd});
    chk({req, " rd_valid"}, {127'b0, rd_valid}, 128'd1);
    chk({req, " rd_data"}, {120'b0, rd_data}, {120'b0, exp});
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", {127'b0, rd_valid}, 128'd0);
    chk("R1 wr_stb", {127'b0, wr_stb}, 128'd0);
    chk("R1 ctrl_regs", ctrl_regs, 128'd0);
    read_chk("R1 addr0", 4'h0, sval(0));
    send(8'h30);
    chk("R1 lo nibble 0", {120'b0, wr_data}, 128'h00);
    exp_ctl[7:0] = 8'h00;
  endtask

  task automatic t_addr_load;
    send(8'h05);
    read_chk("R2 lo load", 4'h0, sval(5));
    send(8'h10);
    read_chk("R2 hi keeps lo", 4'h0, sval(5));
    send(8'h12);
    send(8'h03);
    read_chk("R2 lo keeps hi", 4'h0, 8'hFF);
    send(8'h10);
    read_chk("R2 hi reload", 4'h0, sval(3));
  endtask

  task automatic t_write;
    set_addr(8'h07);
    send(8'h24);
    send(8'h3C);
    chk("R3 wr_stb", {127'b0, wr_stb}, 128'd1);
    chk("R3 wr_addr", {120'b0, wr_addr}, 128'h07);
    chk("R3 wr_data", {120'b0, wr_data}, 128'hC4);
    exp_ctl[7*8 +: 8] = 8'hC4;
    chk("R4 ctrl byte7", ctrl_regs, exp_ctl);
    @(negedge clk);
    chk("R3 wr_stb drop", {127'b0, wr_stb}, 128'd0);
    read_chk("R9 read separate", 4'h0, sval(7));
    set_addr(8'h00);
    send(8'h2E);
    send(8'h3A);
    exp_ctl[7:0] = 8'hAE;
    chk("R4 ctrl byte0", ctrl_regs, exp_ctl);
  endtask

  task automatic t_high;
    set_addr(8'h20);
    send(8'h29);
    send(8'h39);
    chk("R4 high wr_stb", {127'b0, wr_stb}, 128'd1);
    chk("R4 high wr_addr", {120'b0, wr_addr}, 128'h20);
    chk("R4 high no change", ctrl_regs, exp_ctl);
    read_chk("R6 read 0x20", 4'h0, 8'hFF);
    set_addr(8'h10);
    read_chk("R6 read 0x10", 4'h0, 8'hFF);
    set_addr(8'h0F);
    read_chk("R6 read 0x0F mapped", 4'h0, sval(15));
  endtask

  task automatic t_adjust;
    set_addr(8'h0E);
    read_chk("R7 inc pre", 4'h1, sval(14));
    @(negedge clk);
    chk("R5 rd_valid drop", {127'b0, rd_valid}, 128'd0);
    read_chk("R7 inc post", 4'h0, sval(15));
    read_chk("R7 dec pre", 4'h3, sval(15));
    read_chk("R7 dec post", 4'h0, sval(14));
    read_chk("R7 bit1 only", 4'h2, sval(14));
    read_chk("R7 bit1 only hold", 4'h0, sval(14));
    read_chk("R7 inc into 0x10", 4'h1, sval(14));
    read_chk("R7 inc into 0x10b", 4'h1, sval(15));
    read_chk("R7 at 0x10", 4'h0, 8'hFF);
  endtask

  task automatic t_wrap;
    set_addr(8'hFF);
    read_chk("R8 up pre", 4'h1, 8'hFF);
    read_chk("R8 up wrap", 4'h0, sval(0));
    read_chk("R8 down pre", 4'h3, sval(0));
    read_chk("R8 down wrap", 4'h0, 8'hFF);
  endtask

  task automatic t_ignored;
    set_addr(8'h05);
    send(8'h23);
    send(8'h5A);
    chk("R10 op5 no rd", {127'b0, rd_valid}, 128'd0);
    chk("R10 op5 no wr", {127'b0, wr_stb}, 128'd0);
    send(8'h97);
    send(8'hF1);
    chk("R10 opF no wr", {127'b0, wr_stb}, 128'd0);
    send(8'hE2);
    read_chk("R10 addr kept", 4'h0, sval(5));
    send(8'h36);
    chk("R10 lo kept", {120'b0, wr_data}, 128'h63);
    exp_ctl[5*8 +: 8] = 8'h63;
    chk("R10 ctrl5", ctrl_regs, exp_ctl);
  endtask

  task automatic t_novalid;
    set_addr(8'h02);
    send(8'h28);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = 8'h0A;
    @(negedge clk);
    cmd_byte  = 8'h41;
    @(negedge clk);
    chk("R11 no rd", {127'b0, rd_valid}, 128'd0);
    cmd_byte  = 8'h21;
    @(negedge clk);
    cmd_byte  = 8'h3F;
    @(negedge clk);
    chk("R11 no wr", {127'b0, wr_stb}, 128'd0);
    cmd_byte  = 8'h00;
    read_chk("R11 addr kept", 4'h0, sval(2));
    send(8'h31);
    chk("R11 lo kept", {120'b0, wr_data}, 128'h18);
    exp_ctl[2*8 +: 8] = 8'h18;
    chk("R11 ctrl2", ctrl_regs, exp_ctl);
    chk("R9 read unaffected", {120'b0, rexp(8'h02)}, {120'b0, sval(2)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) stat_regs[i*8 +: 8] = sval(i);
    exp_ctl   = '0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_addr_load;
    t_write;
    t_high;
    t_adjust;
    t_wrap;
    t_ignored;
    t_novalid;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule